// File: doc/BRIEF.md
# Processor Control Pin Event Decoder

The decoder watches seven processor control input pins and converts changes on them into interrupt-pending bits, a halt flag, a one-cycle hard-reset request and a time-base run enable. It keeps a registered copy of each pin's last level. A pin is acted on only in a cycle where its sampled level differs from that copy, and each pin has its own rule for what a change does.

Four of the rules follow the pin level: external interrupt, system-management interrupt, soft reset and time-base enable. The machine-check pin reacts only to a falling edge. The checkstop pin can only set halt, and the hard-reset pin fires once on its rising edge. A change on the time-base enable pin also copies its new level into the external-interrupt pending bit. A combined interrupt request is raised while any pending bit is set. Pins are assumed to be synchronous to `clk_i`.

Top module: `ctrl_pin_decoder`

## Requirements
- R1: When `ext_int_i` changes level, pending bit 0 takes the new level one cycle later.
- R2: When `smi_i` changes level, pending bit 1 takes the new level one cycle later.
- R3: A 1-to-0 transition on `mchk_i` sets pending bit 2. Once set, the bit stays set until reset.
- R4: A 0-to-1 transition on `mchk_i` leaves pending bit 2 unchanged.
- R5: A 0-to-1 transition on `ckstop_i` sets `halt_o` one cycle later. Deasserting the pin does not clear `halt_o`; only reset clears it.
- R6: A 0-to-1 transition on `hreset_i` gives a `hreset_req_o` pulse exactly one cycle wide, one cycle later. A 1-to-0 transition gives no pulse.
- R7: When `sreset_i` changes level, pending bit 3 takes the new level one cycle later.
- R8: `tb_run_o` follows the stored level of `tben_i`. A change on `tben_i` also writes its new level into pending bit 0. If `tben_i` and `ext_int_i` change in the same cycle, the `tben_i` level wins.
- R9: `irq_o` is high exactly when `pend_o` is nonzero.
- R10: While `rst_ni` is low, `pend_o`, `halt_o`, `hreset_req_o`, `tb_run_o` and `irq_o` are all 0, and every stored pin level is cleared.
- R11: A pin whose level does not change has no effect. For example, pending bit 0 cleared by a `tben_i` fall stays 0 while `ext_int_i` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_int_i | input | 1 | External interrupt pin |
| smi_i | input | 1 | System-management interrupt pin |
| mchk_i | input | 1 | Machine-check pin |
| ckstop_i | input | 1 | Checkstop pin |
| hreset_i | input | 1 | Hard-reset pin |
| sreset_i | input | 1 | Soft-reset pin |
| tben_i | input | 1 | Time-base enable pin |
| pend_o | output | 4 | Pending bits: 0 external, 1 system-management, 2 machine-check, 3 soft reset |
| irq_o | output | 1 | Combined interrupt request |
| halt_o | output | 1 | Halt flag |
| hreset_req_o | output | 1 | Single-cycle hard-reset request |
| tb_run_o | output | 1 | Time-base run enable |

## Verification
Every result is registered at the clock edge that samples the pin change, so `pend_o`, `halt_o`, `tb_run_o` and `hreset_req_o` are due one cycle after the new level is applied. `irq_o` is due in the same cycle as `pend_o`. The bench drives pins on the falling edge and compares all outputs on the next falling edge against a model stepped once per driven vector, which matches that one-cycle latency. This also checks that the reset pulse has dropped by the following comparison.

// File: rtl/ctrl_pin_pkg.sv
package ctrl_pin_pkg;
  localparam int NUM_PINS   = 7;
  localparam int PIN_EXT    = 0;
  localparam int PIN_SMI    = 1;
  localparam int PIN_MCHK   = 2;
  localparam int PIN_CKSTOP = 3;
  localparam int PIN_HRESET = 4;
  localparam int PIN_SRESET = 5;
  localparam int PIN_TBEN   = 6;

  localparam int NUM_PEND    = 4;
  localparam int PEND_EXT    = 0;
  localparam int PEND_SMI    = 1;
  localparam int PEND_MCHK   = 2;
  localparam int PEND_SRESET = 3;

  typedef logic [NUM_PINS-1:0] pin_vec_t;
  typedef logic [NUM_PEND-1:0] pend_vec_t;
endpackage

// File: rtl/pin_edge_bank.sv
module pin_edge_bank #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] prev_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= 1'b0;
      else         lvl_q <= pin_i[g];
    end
    assign prev_o[g] = lvl_q;
    assign rise_o[g] = pin_i[g] & ~lvl_q;
    assign fall_o[g] = ~pin_i[g] & lvl_q;

    // R11
    level_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> prev_o[g] == $past(pin_i[g]));
  end
endmodule

// File: rtl/pend_reg.sv
module pend_reg
  import ctrl_pin_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pin_vec_t  pin_i,
  input  pin_vec_t  rise_i,
  input  pin_vec_t  fall_i,
  output pend_vec_t pend_o
);
  pin_vec_t  chg;
  pend_vec_t pend_q, pend_d;

  assign chg = rise_i | fall_i;

  always_comb begin
    pend_d = pend_q;
    if (chg[PIN_EXT])    pend_d[PEND_EXT]    = pin_i[PIN_EXT];
    // time-base enable change overrides the external pin in the same cycle
    if (chg[PIN_TBEN])   pend_d[PEND_EXT]    = pin_i[PIN_TBEN];
    if (chg[PIN_SMI])    pend_d[PEND_SMI]    = pin_i[PIN_SMI];
    if (fall_i[PIN_MCHK]) pend_d[PEND_MCHK]  = 1'b1;
    if (chg[PIN_SRESET]) pend_d[PEND_SRESET] = pin_i[PIN_SRESET];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R1
  ext_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg[PIN_EXT] && !chg[PIN_TBEN]) |=> pend_o[PEND_EXT] == $past(pin_i[PIN_EXT]));
  // R2
  smi_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg[PIN_SMI] |=> pend_o[PEND_SMI] == $past(pin_i[PIN_SMI]));
  // R3
  mchk_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o[PEND_MCHK] |=> pend_o[PEND_MCHK]);
  // R4
  mchk_rise_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i[PIN_MCHK] && !pend_o[PEND_MCHK]) |=> !pend_o[PEND_MCHK]);
  // R7
  sreset_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg[PIN_SRESET] |=> pend_o[PEND_SRESET] == $past(pin_i[PIN_SRESET]));
  // R8
  tben_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg[PIN_TBEN] |=> pend_o[PEND_EXT] == $past(pin_i[PIN_TBEN]));
endmodule

// File: rtl/ctrl_pin_decoder.sv
module ctrl_pin_decoder
  import ctrl_pin_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ext_int_i,
  input  logic                smi_i,
  input  logic                mchk_i,
  input  logic                ckstop_i,
  input  logic                hreset_i,
  input  logic                sreset_i,
  input  logic                tben_i,
  output logic [NUM_PEND-1:0] pend_o,
  output logic                irq_o,
  output logic                halt_o,
  output logic                hreset_req_o,
  output logic                tb_run_o
);
  pin_vec_t pins, prev, rise, fall;
  logic     halt_q, req_q;

  always_comb begin
    pins             = '0;
    pins[PIN_EXT]    = ext_int_i;
    pins[PIN_SMI]    = smi_i;
    pins[PIN_MCHK]   = mchk_i;
    pins[PIN_CKSTOP] = ckstop_i;
    pins[PIN_HRESET] = hreset_i;
    pins[PIN_SRESET] = sreset_i;
    pins[PIN_TBEN]   = tben_i;
  end

  pin_edge_bank #(.N(NUM_PINS)) u_edges (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pins),
    .prev_o (prev),
    .rise_o (rise),
    .fall_o (fall)
  );

  pend_reg u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pins),
    .rise_i (rise),
    .fall_i (fall),
    .pend_o (pend_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (rise[PIN_CKSTOP]) halt_q <= 1'b1;
      req_q <= rise[PIN_HRESET];
    end
  end

  assign halt_o       = halt_q;
  assign hreset_req_o = req_q;
  assign irq_o        = |pend_o;
  assign tb_run_o     = prev[PIN_TBEN];

  // R5
  halt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise[PIN_CKSTOP] |=> halt_o);
  // R5
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  // R6
  hreset_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise[PIN_HRESET] |=> hreset_req_o);
  // R6
  hreset_one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreset_req_o |=> !hreset_req_o);
  // R8
  tb_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tb_run_o == $past(tben_i));
endmodule

// File: tb/ctrl_pin_decoder_bench.sv
module ctrl_pin_decoder_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] pv = '0; // 0 ext,1 smi,2 mchk,3 ckstop,4 hreset,5 sreset,6 tben
  logic [3:0] pend_o;
  logic       irq_o, halt_o, hreset_req_o, tb_run_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [6:0] m_prev = '0;
  logic [3:0] m_pend = '0;
  logic       m_halt = 1'b0;
  logic       m_req  = 1'b0;

  always #2 clk_i = ~clk_i;

  ctrl_pin_decoder u_ctrl_pin_decoder (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ext_int_i    (pv[0]),
    .smi_i        (pv[1]),
    .mchk_i       (pv[2]),
    .ckstop_i     (pv[3]),
    .hreset_i     (pv[4]),
    .sreset_i     (pv[5]),
    .tben_i       (pv[6]),
    .pend_o       (pend_o),
    .irq_o        (irq_o),
    .halt_o       (halt_o),
    .hreset_req_o (hreset_req_o),
    .tb_run_o     (tb_run_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1/R8 pend[0]", pend_o[0], m_pend[0]);
    chk("R2 pend[1]", pend_o[1], m_pend[1]);
    chk("R3/R4 pend[2]", pend_o[2], m_pend[2]);
    chk("R7 pend[3]", pend_o[3], m_pend[3]);
    chk("R9 irq", irq_o, int'(m_pend != 0));
    chk("R5 halt", halt_o, m_halt);
    chk("R6 hreset_req", hreset_req_o, m_req);
    chk("R8 tb_run", tb_run_o, m_prev[6]);
  endtask

  function automatic logic [3:0] next_pend(input logic [6:0] p, input logic [6:0] q,
                                           input logic [3:0] cur);
    logic [3:0] n = cur;
    if (p[0] != q[0]) n[0] = p[0];
    if (p[6] != q[6]) n[0] = p[6];
    if (p[1] != q[1]) n[1] = p[1];
    if (!p[2] && q[2]) n[2] = 1'b1;
    if (p[5] != q[5]) n[3] = p[5];
    return n;
  endfunction

  // check previous cycle's results, then drive a new vector and step the model
  task automatic step(input logic [6:0] p);
    @(negedge clk_i);
    check_all();
    pv = p;
    m_pend = next_pend(p, m_prev, m_pend);
    if (p[3] && !m_prev[3]) m_halt = 1'b1;
    m_req  = p[4] && !m_prev[4];
    m_prev = p;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    pv = '0;
    m_prev = '0; m_pend = '0; m_halt = 1'b0; m_req = 1'b0;
    @(negedge clk_i);
    // R10
    chk("R10 pend", pend_o, 0);
    chk("R10 irq", irq_o, 0);
    chk("R10 halt", halt_o, 0);
    chk("R10 req", hreset_req_o, 0);
    chk("R10 tb_run", tb_run_o, 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h1d5e));
    do_reset();
    // R1, R9: ext level follow
    step(7'b000_0001); step(7'b000_0000); step(7'b000_0000);
    // R2, R7
    step(7'b000_0010); step(7'b010_0010); step(7'b010_0000); step(7'b000_0000);
    // R8, R11: tben fall clears ext pending while ext held high
    step(7'b100_0001); step(7'b000_0001); step(7'b000_0001); step(7'b000_0001);
    // R8: same-cycle ext rise and tben fall, tben wins
    step(7'b100_0000); step(7'b000_0001); step(7'b000_0001);
    // R6: rise pulse, held high, fall gives nothing
    step(7'b001_0000); step(7'b001_0000); step(7'b001_0000); step(7'b000_0000); step(7'b000_0000);
    // R5: ckstop set, release keeps halt
    step(7'b000_1000); step(7'b000_0000); step(7'b000_0000);
    // R4 then R3
    step(7'b000_0100); step(7'b000_0100); step(7'b000_0000); step(7'b000_0001);
    step(7'b000_0000); step(7'b000_0000);
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] p = pv;
      for (int b = 0; b < 7; b++)
        if (($urandom % 6) == 0) p[b] = ~p[b];
      step(p);
      if ((i % 200) == 199) do_reset();
    end
    step(pv);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule